// File: doc/BRIEF.md
# Two-Wire Debug Frame Transceiver

This block is the master end of a two-wire debug link. The master always drives the clock line. The data line is shared and changes direction. A controller hands the block one request at a time through a request/ready handshake. A request can send one byte, receive one byte, or attach the link. A byte is sent as a twelve-bit character: a low start bit, the eight data bits with the least significant bit first, an even parity bit and two high stop bits. The master sends one clock pulse for each bit.

To receive, the block stops driving the data line and keeps pulsing the clock. After each pulse it looks for the target's start bit. The number of pulses it spends looking is limited. Once it finds the start bit, it always clocks in the rest of the frame, even when the frame turns out to be bad. This keeps the master and the target aligned on frame boundaries. The result is a byte plus two flags: an error flag and a timeout flag. All three stay valid until the next request is accepted.

The attach operation wakes up the link. It pulls data low while the clock is high and turns on both line drivers. It then raises data and holds it for a fixed settle time. Next it sends a run of idle clock pulses with data high. Last, it sends two bytes that enable the link (0xC2, then 0x02).

States and transitions of the controller:
- IDLE goes to TX_FRAME for a send, to RX_HUNT for a receive, and to ATT_LOW for an attach.
- ATT_LOW goes to ATT_HOLD after one slot.
- ATT_HOLD goes to ATT_PULSE after HOLD_SLOTS slots.
- ATT_PULSE goes to TX_FRAME, with a two-byte chain armed, after IDLE_PULSES slots.
- TX_FRAME stays in TX_FRAME to send the second chained byte. Otherwise it goes to DONE after 12 slots.
- RX_HUNT goes to RX_BITS when it samples a low bit. It goes to DONE with a timeout after HUNT_LIMIT slots with no start bit.
- RX_BITS goes to RX_CHECK after 11 slots.
- RX_CHECK goes to DONE.
- DONE goes to IDLE.

Top module: `dbgw_transceiver`

## Requirements
- R1: A send puts exactly 12 clock pulses on the line. The data bit seen at each rising edge follows this order: 0 (start bit), data bits 0 to 7, the even-parity bit (the XOR of the data bits), 1, 1. The data driver stays enabled throughout.
- R2: Each bit slot lasts 2*CLK_DIV system cycles. In a slot, the clock is low during cycles 1 to CLK_DIV and high in all other cycles. A driven data line changes only while the clock is high and was already high in the previous cycle. A send therefore takes 24*CLK_DIV cycles from acceptance until the cycle before done.
- R3: During a receive the data driver is disabled. The line is sampled in the last cycle of each slot, after the rising edge.
- R4: After a start bit is found, the block samples 8 data bits (least significant bit first), then the parity bit, then two stop bits. A good frame returns its byte on rsp_data with both flags low.
- R5: If the parity does not match, or either stop bit is 0, rsp_err goes high and rsp_data is 0.
- R6: Once a start bit is found, a receive always issues the full 11 further clock pulses, whether or not the frame has an error. done appears at cycle 4*CLK_DIV*(D+12)/2+2 after acceptance, where D is the number of high bits the target sent before its start bit.
- R7: If HUNT_LIMIT pulses pass with no low sample, the receive ends with rsp_timeout high, rsp_err low and rsp_data 0, after exactly HUNT_LIMIT pulses. A start bit found on the last allowed pulse is still accepted.
- R8: Attach runs in this order: data 0 with clock high and both drivers on, then data 1 for HOLD_SLOTS slots with no clock pulse, then IDLE_PULSES pulses with data 1, then the frames for 0xC2 and 0x02. After an attach the data driver stays enabled while the block is idle.
- R9: The op codes are 00 send, 01 receive, 10 attach. Code 11 is ignored: the block does not go busy and puts no pulse on the line. A request is taken only when req_ready is high, and req_ready is the inverse of busy.
- R10: done is high for exactly one cycle. rsp_data, rsp_err and rsp_timeout keep their values until the next request is accepted, and they are cleared in that same cycle.
- R11: After reset the block is idle and ready. The clock line is high, the data driver is off, and done and both flags are low.
- R12: busy stays high from acceptance through the done cycle, and falls only right after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 00 send, 01 receive, 10 attach, 11 ignored |
| req_data | input | 8 | Byte to send |
| req_ready | output | 1 | Block is idle and can take a request |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Received byte, or 0 on error or timeout |
| rsp_err | output | 1 | Parity or stop-bit error on the last receive |
| rsp_timeout | output | 1 | No start bit seen on the last receive |
| line_clk | output | 1 | Debug clock line |
| line_dout | output | 1 | Data line drive value |
| line_oe | output | 1 | Data line driver enable |
| line_din | input | 1 | Data line sampled value |

## Verification
The bench builds the block with CLK_DIV=2, the shortest legal slot. In that slot the rising edge of the clock is only one cycle away from the next data change, so the clock-high rule for data is tested with the least margin. HUNT_LIMIT=8 makes the search for a start bit short enough to test both boundaries: a start bit on the eighth pulse, and a timeout on the pulse after it. HOLD_SLOTS=2 and the full 16 idle pulses keep the attach sequence at its intended shape.

// File: rtl/dbgw_pkg.sv
`timescale 1ns/1ps
package dbgw_pkg;

    typedef enum logic [1:0] {
        OP_SEND   = 2'b00,
        OP_RECV   = 2'b01,
        OP_ATTACH = 2'b10,
        OP_RSVD   = 2'b11
    } dbgw_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ATT_LOW,
        S_ATT_HOLD,
        S_ATT_PULSE,
        S_TX_FRAME,
        S_RX_HUNT,
        S_RX_BITS,
        S_RX_CHECK,
        S_DONE
    } dbgw_state_e;

    localparam int FRAME_SLOTS = 12;   // start + 8 data + parity + 2 stop
    localparam int RX_TAIL     = 11;   // slots clocked after the start bit
    localparam logic [7:0] WAKE_BYTE0 = 8'hC2;
    localparam logic [7:0] WAKE_BYTE1 = 8'h02;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/dbgw_slot_timer.sv
`timescale 1ns/1ps
module dbgw_slot_timer #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_low,
    output logic slot_end
);
    localparam int SLOT = 2 * CLK_DIV;
    localparam int CW   = $clog2(SLOT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == CW'(SLOT - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // clock low during cycles 1..CLK_DIV of a slot, high elsewhere
    assign clk_low  = run && (cnt_q >= CW'(1)) && (cnt_q <= CW'(CLK_DIV));
    assign slot_end = run && (cnt_q == CW'(SLOT - 1));

endmodule

// File: rtl/dbgw_tx_framer.sv
`timescale 1ns/1ps
module dbgw_tx_framer
    import dbgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] byte_in,
    input  logic [3:0] slot_idx,
    output logic       bit_out
);
    logic [7:0]             byte_q;
    logic [FRAME_SLOTS-1:0] frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= 8'h00;
        end else if (load) begin
            byte_q <= byte_in;
        end
    end

    assign frame   = {2'b11, even_par(byte_q), byte_q, 1'b0};
    assign bit_out = (slot_idx < 4'(FRAME_SLOTS)) ? frame[slot_idx] : 1'b1;

endmodule

// File: rtl/dbgw_rx_collector.sv
`timescale 1ns/1ps
module dbgw_rx_collector
    import dbgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift,
    input  logic       din,
    output logic [7:0] data,
    output logic       good
);
    logic [RX_TAIL-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clear) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= {din, sr_q[RX_TAIL-1:1]};
        end
    end

    // after 11 shifts: [7:0] data, [8] parity, [9] first stop, [10] second stop
    assign data = sr_q[7:0];
    assign good = (even_par(sr_q[7:0]) == sr_q[8]) && sr_q[9] && sr_q[10];

endmodule

// File: rtl/dbgw_transceiver.sv
`timescale 1ns/1ps
module dbgw_transceiver
    import dbgw_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int HUNT_LIMIT  = 256,
    parameter int IDLE_PULSES = 16,
    parameter int HOLD_SLOTS  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [7:0] req_data,
    output logic       req_ready,
    output logic       busy,
    output logic       done,
    output logic [7:0] rsp_data,
    output logic       rsp_err,
    output logic       rsp_timeout,
    output logic       line_clk,
    output logic       line_dout,
    output logic       line_oe,
    input  logic       line_din
);
    localparam int M1      = (HUNT_LIMIT > IDLE_PULSES) ? HUNT_LIMIT : IDLE_PULSES;
    localparam int M2      = (HOLD_SLOTS > FRAME_SLOTS) ? HOLD_SLOTS : FRAME_SLOTS;
    localparam int IDX_MAX = (M1 > M2) ? M1 : M2;
    localparam int IDX_W   = $clog2(IDX_MAX + 1);

    dbgw_state_e      st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             chain_q, chain_d;
    logic             attached_q;
    logic [7:0]       data_q;
    logic             err_q, to_q;

    logic       accept;
    logic       run, pulsing, clk_low, slot_end;
    logic       tx_load, tx_bit;
    logic [7:0] tx_byte;
    logic       rx_clear, rx_shift, rx_good;
    logic [7:0] rx_data;
    logic       set_rx, set_to;

    assign accept = req_valid && (st_q == S_IDLE) && (dbgw_op_e'(req_op) != OP_RSVD);

    always_comb begin
        unique case (st_q)
            S_ATT_LOW, S_ATT_HOLD, S_ATT_PULSE,
            S_TX_FRAME, S_RX_HUNT, S_RX_BITS: run = 1'b1;
            default:                          run = 1'b0;
        endcase
        pulsing = (st_q == S_ATT_PULSE) || (st_q == S_TX_FRAME) ||
                  (st_q == S_RX_HUNT)   || (st_q == S_RX_BITS);
    end

    dbgw_slot_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clk_low  (clk_low),
        .slot_end (slot_end)
    );

    dbgw_tx_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .byte_in  (tx_byte),
        .slot_idx (idx_q[3:0]),
        .bit_out  (tx_bit)
    );

    dbgw_rx_collector u_collect (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rx_clear),
        .shift (rx_shift),
        .din   (line_din),
        .data  (rx_data),
        .good  (rx_good)
    );

    // next-state and sequencing decisions
    always_comb begin
        st_d     = st_q;
        idx_d    = idx_q;
        chain_d  = chain_q;
        tx_load  = 1'b0;
        tx_byte  = req_data;
        rx_clear = 1'b0;
        rx_shift = 1'b0;
        set_rx   = 1'b0;
        set_to   = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (accept) begin
                    idx_d = '0;
                    unique case (dbgw_op_e'(req_op))
                        OP_SEND: begin
                            st_d    = S_TX_FRAME;
                            tx_load = 1'b1;
                            chain_d = 1'b0;
                        end
                        OP_RECV: begin
                            st_d     = S_RX_HUNT;
                            rx_clear = 1'b1;
                        end
                        OP_ATTACH: st_d = S_ATT_LOW;
                        default:   st_d = S_IDLE;
                    endcase
                end
            end
            S_ATT_LOW: begin
                if (slot_end) begin
                    st_d  = S_ATT_HOLD;
                    idx_d = '0;
                end
            end
            S_ATT_HOLD: begin
                if (slot_end) begin
                    if (idx_q == IDX_W'(HOLD_SLOTS - 1)) begin
                        st_d  = S_ATT_PULSE;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            S_ATT_PULSE: begin
                if (slot_end) begin
                    if (idx_q == IDX_W'(IDLE_PULSES - 1)) begin
                        st_d    = S_TX_FRAME;
                        idx_d   = '0;
                        tx_load = 1'b1;
                        tx_byte = WAKE_BYTE0;
                        chain_d = 1'b1;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            S_TX_FRAME: begin
                if (slot_end) begin
                    if (idx_q == IDX_W'(FRAME_SLOTS - 1)) begin
                        idx_d = '0;
                        if (chain_q) begin
                            tx_load = 1'b1;
                            tx_byte = WAKE_BYTE1;
                            chain_d = 1'b0;
                        end else begin
                            st_d = S_DONE;
                        end
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            S_RX_HUNT: begin
                if (slot_end) begin
                    if (!line_din) begin
                        st_d  = S_RX_BITS;
                        idx_d = '0;
                    end else if (idx_q == IDX_W'(HUNT_LIMIT - 1)) begin
                        st_d   = S_DONE;
                        idx_d  = '0;
                        set_to = 1'b1;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            S_RX_BITS: begin
                if (slot_end) begin
                    rx_shift = 1'b1;
                    if (idx_q == IDX_W'(RX_TAIL - 1)) begin
                        st_d  = S_RX_CHECK;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            S_RX_CHECK: begin
                st_d   = S_DONE;
                set_rx = 1'b1;
            end
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            idx_q   <= '0;
            chain_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            idx_q   <= idx_d;
            chain_q <= chain_d;
        end
    end

    // response and line-attach registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= 8'h00;
            err_q      <= 1'b0;
            to_q       <= 1'b0;
            attached_q <= 1'b0;
        end else begin
            if (accept) begin
                data_q <= 8'h00;
                err_q  <= 1'b0;
                to_q   <= 1'b0;
                if (dbgw_op_e'(req_op) == OP_ATTACH) attached_q <= 1'b1;
            end
            if (set_to) begin
                to_q   <= 1'b1;
                data_q <= 8'h00;
            end
            if (set_rx) begin
                err_q  <= !rx_good;
                data_q <= rx_good ? rx_data : 8'h00;
            end
        end
    end

    // outputs
    always_comb begin
        line_clk  = !(pulsing && clk_low);
        line_dout = 1'b1;
        line_oe   = attached_q;
        unique case (st_q)
            S_ATT_LOW: begin
                line_dout = 1'b0;
                line_oe   = 1'b1;
            end
            S_ATT_HOLD, S_ATT_PULSE: line_oe = 1'b1;
            S_TX_FRAME: begin
                line_dout = tx_bit;
                line_oe   = 1'b1;
            end
            S_RX_HUNT, S_RX_BITS, S_RX_CHECK: line_oe = 1'b0;
            default: ;
        endcase
        req_ready   = (st_q == S_IDLE);
        busy        = (st_q != S_IDLE);
        done        = (st_q == S_DONE);
        rsp_data    = data_q;
        rsp_err     = err_q;
        rsp_timeout = to_q;
    end

    // R2: driven data moves only while the line clock has been high
    a_r2_data_moves_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !$stable(line_dout)) |-> (line_clk && $past(line_clk)));

    // R5: an errored frame never returns data
    a_r5_error_clears_data: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_err) |-> (rsp_data == 8'h00));

    // R7: timeout is exclusive with error and returns zero
    a_r7_timeout_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_timeout) |-> (!rsp_err && rsp_data == 8'h00));

    // R10: completion pulse lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: busy holds until done, and only falls after done
    a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r12_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

// File: tb/dbgw_transceiver_tb.sv
`timescale 1ns/1ps
module dbgw_transceiver_tb;

    localparam int DIV  = 2;
    localparam int HUNT = 8;
    localparam int IDLP = 16;
    localparam int HOLD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [7:0] req_data = 8'h00;
    logic       req_ready, busy, done, rsp_err, rsp_timeout;
    logic [7:0] rsp_data;
    logic       line_clk, line_dout, line_oe;
    logic       line_din = 1'b1;

    dbgw_transceiver #(
        .CLK_DIV(DIV), .HUNT_LIMIT(HUNT), .IDLE_PULSES(IDLP), .HOLD_SLOTS(HOLD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_ready(req_ready), .busy(busy), .done(done),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
        .line_clk(line_clk), .line_dout(line_dout), .line_oe(line_oe),
        .line_din(line_din)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_checks = 0;
    int n_err    = 0;

    // line capture at rising clock edges
    logic cap_bits [0:63];
    logic cap_oe   [0:63];
    int   cap_n  = 0;
    logic cap_on = 1'b0;
    always @(posedge line_clk) begin
        if (cap_on && cap_n < 64) begin
            cap_bits[cap_n] = line_dout;
            cap_oe[cap_n]   = line_oe;
            cap_n++;
        end
    end

    // target model: next bit placed on each falling clock edge
    logic tgt_bits [0:63];
    int   tgt_len = 0;
    int   tgt_ptr = 0;
    logic tgt_on  = 1'b0;
    always @(negedge line_clk) begin
        if (tgt_on && tgt_ptr < tgt_len) begin
            line_din = tgt_bits[tgt_ptr];
            tgt_ptr++;
        end else begin
            line_din = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] b);
        return {2'b11, ^b, b, 1'b0};
    endfunction

    function automatic logic [11:0] cap_word(input int base);
        logic [11:0] w;
        for (int i = 0; i < 12; i++) w[i] = cap_bits[base + i];
        return w;
    endfunction

    function automatic logic cap_oe_all(input int val);
        for (int i = 0; i < cap_n; i++) if (cap_oe[i] !== val[0]) return 1'b0;
        return 1'b1;
    endfunction

    int   cyc;
    logic busy_gap;
    logic k1_dout, k1_oe, k1_clk, k1_err, k1_to;

    task automatic issue(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d;
        cap_n = 0; cap_on = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k1_dout = line_dout; k1_oe = line_oe; k1_clk = line_clk;
        k1_err = rsp_err; k1_to = rsp_timeout;
        cyc = 1; busy_gap = 1'b0;
        while (!done && cyc < 4000) begin
            if (!busy) busy_gap = 1'b1;
            @(negedge clk);
            cyc++;
        end
        cap_on = 1'b0;
    endtask

    task automatic do_send(input logic [7:0] b);
        issue(2'b00, b);
        chk("R1 pulse count", cap_n, 12);
        chk("R1 frame bits", cap_word(0), exp_frame(b));
        chk("R1 driver on", cap_oe_all(1), 1);
        chk("R2 send length", cyc, 24 * DIV + 1);
        chk("R12 busy held", busy_gap, 0);
        chk("R10 flags cleared on accept", {k1_err, k1_to}, 0);
    endtask

    task automatic do_recv(input int dly, input logic [7:0] b, input logic pflip,
                           input logic s1, input logic s2);
        logic good;
        int   n = 0;
        for (int i = 0; i < dly && n < 64; i++) tgt_bits[n++] = 1'b1;
        if (n < 52) begin
            tgt_bits[n++] = 1'b0;
            for (int i = 0; i < 8; i++) tgt_bits[n++] = b[i];
            tgt_bits[n++] = (^b) ^ pflip;
            tgt_bits[n++] = s1;
            tgt_bits[n++] = s2;
        end
        tgt_len = n; tgt_ptr = 0; tgt_on = 1'b1;
        issue(2'b01, 8'h00);
        tgt_on = 1'b0;
        chk("R3 driver released", cap_oe_all(0), 1);
        chk("R12 busy held", busy_gap, 0);
        if (dly >= HUNT) begin
            chk("R7 timeout flag", rsp_timeout, 1);
            chk("R7 timeout no err", rsp_err, 0);
            chk("R7 timeout data", rsp_data, 0);
            chk("R7 hunt pulses", cap_n, HUNT);
            chk("R7 timeout length", cyc, HUNT * 2 * DIV + 1);
        end else begin
            good = !pflip && s1 && s2;
            chk("R4 rx data", rsp_data, good ? b : 8'h00);
            chk("R5 rx err flag", rsp_err, !good);
            chk("R7 no timeout", rsp_timeout, 0);
            chk("R6 rx pulses", cap_n, dly + 12);
            chk("R6 rx length", cyc, (dly + 12) * 2 * DIV + 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int          seed;
        logic [7:0]  rb;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", req_ready, 1);
        chk("R11 busy", busy, 0);
        chk("R11 clk high", line_clk, 1);
        chk("R11 driver off", line_oe, 0);
        chk("R11 done/flags", {done, rsp_err, rsp_timeout}, 0);

        // R9 reserved op ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11; cap_n = 0; cap_on = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 reserved op not busy", busy, 0);
        repeat (10) @(negedge clk);
        cap_on = 1'b0;
        chk("R9 reserved op no pulses", cap_n, 0);
        chk("R9 ready is not busy", req_ready, !busy);

        // R1/R2 directed and random sends
        do_send(8'h00);
        do_send(8'hFF);
        do_send(8'hA5);
        do_send(8'h80);
        for (int i = 0; i < 6; i++) begin
            rb = 8'($urandom);
            do_send(rb);
        end

        // R8 attach
        issue(2'b10, 8'h00);
        chk("R8 first phase data low", k1_dout, 0);
        chk("R8 first phase drivers on", k1_oe, 1);
        chk("R8 first phase clock high", k1_clk, 1);
        chk("R8 pulse count", cap_n, IDLP + 24);
        begin
            logic ones = 1'b1;
            for (int i = 0; i < IDLP; i++) if (cap_bits[i] !== 1'b1) ones = 1'b0;
            chk("R8 idle pulses data high", ones, 1);
        end
        chk("R8 first wake byte", cap_word(IDLP), exp_frame(8'hC2));
        chk("R8 second wake byte", cap_word(IDLP + 12), exp_frame(8'h02));
        chk("R8 attach length", cyc, (1 + HOLD + IDLP + 24) * 2 * DIV + 1);
        @(negedge clk);
        chk("R8 driver kept after attach", line_oe, 1);

        // R4/R6 good receives
        do_recv(0, 8'h3C, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) begin
            rb = 8'($urandom);
            do_recv(int'($urandom % HUNT), rb, 1'b0, 1'b1, 1'b1);
        end
        // R7 boundaries
        do_recv(HUNT - 1, 8'h5A, 1'b0, 1'b1, 1'b1);
        do_recv(HUNT, 8'h5A, 1'b0, 1'b1, 1'b1);
        // R5 errors with full length
        do_recv(2, 8'hC3, 1'b1, 1'b1, 1'b1);
        do_recv(1, 8'h7E, 1'b0, 1'b0, 1'b1);
        do_recv(3, 8'h01, 1'b0, 1'b1, 1'b0);

        // R10 flags held until next request
        repeat (10) @(negedge clk);
        chk("R10 err held", rsp_err, 1);
        chk("R10 done low after pulse", done, 0);
        do_send(8'h11);
        chk("R10 err cleared by send", rsp_err, 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule